// File: doc/BRIEF.md
# DDR Refresh Scheduler with Postponement Credit

The block sits on the controller side of a DDR SDRAM interface and decides when the memory must be refreshed. A free-running interval counter fires once per average refresh period (7.8 µs, which spreads 8192 refreshes over 64 ms) and each firing adds one owed refresh to a credit counter. While the credit is non-zero the block raises a refresh request to the command arbiter. The arbiter may let the request wait while traffic is heavy. Once eight refreshes are owed the request is flagged urgent, so that the gap between two refreshes never exceeds the 70.3 µs absolute limit.

When the arbiter grants a pending request, the block takes the command bus for one full refresh sequence. It issues a precharge-all, waits the row precharge time, issues one AUTO REFRESH, and then holds the bus for the refresh recovery time with the clock enable kept high. The controller can also put the memory into self refresh. Clock enable is then driven low, owed refreshes are dropped and the interval counter stops. On exit the block times two separate holds: a short one before any non-read command, and a 200-cycle one before a READ.

All timings are given in picoseconds and converted to cycle counts from the clock period. Minimum delays are rounded up and the refresh interval is rounded down.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ref_req`, `ref_urgent`, `cmd_pre_all` and `cmd_refresh` are 0, `posted` is 0, and `cke`, `ok_nonread` and `ok_read` are 1.
- R2: Outside self refresh, `posted` rises by one on every T_REFI-th clock edge after reset release or self-refresh exit. `ref_req` is 1 exactly when `posted` is non-zero and `ok_nonread` is 1.
- R3: `posted` saturates at MAX_POST (8). `ref_urgent` is 1 exactly when `posted` equals MAX_POST.
- R4: A `ref_gnt` sampled while `ref_req` is 1 makes `cmd_pre_all` high for the next cycle only. `cmd_refresh` is then high for one cycle exactly T_RP cycles after `cmd_pre_all`. A `ref_gnt` sampled while `ref_req` is 0 causes no command.
- R5: Each grant yields exactly one refresh. `ref_req` stays low from the precharge until the sequence ends. In the `cmd_refresh` cycle `posted` shows one less than the owed count, or the same count when a tick lands on that edge.
- R6: From the `cmd_refresh` cycle through the next T_RFC-1 cycles, `cke` stays 1 and `ok_nonread`, `ok_read` and `ref_req` stay 0. `ok_nonread` returns to 1 exactly T_RFC cycles after `cmd_refresh`.
- R7: `sr_enter` is accepted only while `ok_nonread` is 1 and no grant is being taken. From the next cycle, `cke` is 0, `posted` is 0 and no ticks accumulate. `sr_enter` during a refresh sequence has no effect.
- R8: After `sr_exit` is sampled in self refresh, `cke` is 1 in the next cycle (cycle 0). `ok_nonread` turns 1 at cycle T_XSNR and `ok_read` turns 1 at cycle T_XSRD. The interval count restarts from cycle 0.
- R9: When `ref_gnt` (with `ref_req` high) and `sr_enter` are sampled in the same cycle, the refresh sequence starts and self refresh is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grants the command bus to the refresh sequence |
| sr_enter | input | 1 | Controller asks to enter self refresh |
| sr_exit | input | 1 | Controller asks to leave self refresh |
| ref_req | output | 1 | At least one refresh is owed and the bus may be taken |
| ref_urgent | output | 1 | Credit is full; the refresh must preempt traffic |
| posted | output | $clog2(MAX_POST+1) | Number of owed refreshes |
| cmd_pre_all | output | 1 | Issue precharge-all this cycle |
| cmd_refresh | output | 1 | Issue AUTO REFRESH this cycle |
| cke | output | 1 | Clock enable to the memory |
| ok_nonread | output | 1 | A non-read command may be issued |
| ok_read | output | 1 | A READ may be issued |

## Verification
The bound checker enforces these on every cycle:
- the credit ceiling and the precharge-to-refresh spacing;
- that a precharge follows only a granted request and drops the request;
- that the credit falls by at most one on a refresh;
- that the recovery window keeps clock enable high and blocks commands;
- that self refresh keeps every output quiet, and that read readiness implies non-read readiness.

Only the bench scenarios show the rest:
- the exact tick cadence and saturation at eight;
- that grants without a pending request and mid-sequence self-refresh requests are ignored;
- that a grant wins over a simultaneous self-refresh request;
- the two exit delays and the restart of the interval after exit.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_PS   = 4000,
  parameter int REFI_PS  = 7_800_000,
  parameter int TRP_PS   = 15_000,
  parameter int TRFC_PS  = 75_000,
  parameter int TXSNR_PS = 75_000,
  parameter int XSRD_CYC = 200,
  parameter int MAX_POST = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ref_gnt,
  input  logic                          sr_enter,
  input  logic                          sr_exit,
  output logic                          ref_req,
  output logic                          ref_urgent,
  output logic [$clog2(MAX_POST+1)-1:0] posted,
  output logic                          cmd_pre_all,
  output logic                          cmd_refresh,
  output logic                          cke,
  output logic                          ok_nonread,
  output logic                          ok_read
);
  localparam int T_REFI  = (REFI_PS / CLK_PS < 2) ? 2 : REFI_PS / CLK_PS;
  localparam int RP_RAW  = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int RFC_RAW = (TRFC_PS + CLK_PS - 1) / CLK_PS;
  localparam int T_RP    = (RP_RAW < 2) ? 2 : RP_RAW;
  localparam int T_RFC   = (RFC_RAW < 2) ? 2 : RFC_RAW;
  localparam int XN_RAW  = (TXSNR_PS + CLK_PS - 1) / CLK_PS;
  localparam int T_XSNR  = (XN_RAW < 1) ? 1 : XN_RAW;
  localparam int T_XSRD  = (XSRD_CYC < T_XSNR) ? T_XSNR : XSRD_CYC;
  localparam int PW      = $clog2(MAX_POST + 1);
  localparam int TMAX    = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int TW      = $clog2(TMAX);
  localparam int IW      = $clog2(T_REFI);
  localparam int XW      = $clog2(T_XSRD + 1);

  localparam logic [PW-1:0] POST_CAP = PW'(MAX_POST);
  localparam logic [IW-1:0] ICNT_TOP = IW'(T_REFI - 1);
  localparam logic [TW-1:0] RP_LOAD  = TW'(T_RP - 2);
  localparam logic [TW-1:0] RFC_LOAD = TW'(T_RFC - 2);
  localparam logic [XW-1:0] XSNR_V   = XW'(T_XSNR);
  localparam logic [XW-1:0] XSRD_V   = XW'(T_XSRD);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_WRP, ST_REF, ST_RFC, ST_SR
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [IW-1:0] icnt;
  logic [XW-1:0] xcnt;

  logic idle, in_sr, take, sleep, tick, dec;

  assign idle  = (st == ST_IDLE);
  assign in_sr = (st == ST_SR);

  assign ok_nonread  = idle && (xcnt >= XSNR_V);
  assign ok_read     = idle && (xcnt >= XSRD_V);
  assign ref_req     = ok_nonread && (posted != '0);
  assign ref_urgent  = (posted == POST_CAP);
  assign cmd_pre_all = (st == ST_PRE);
  assign cmd_refresh = (st == ST_REF);
  assign cke         = !in_sr;

  assign take  = ref_req && ref_gnt;
  assign sleep = ok_nonread && !take && sr_enter;
  assign tick  = !in_sr && (icnt == ICNT_TOP);
  assign dec   = (st == ST_WRP) && (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      tmr <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (take)       st <= ST_PRE;
          else if (sleep) st <= ST_SR;
        end
        ST_PRE: begin
          tmr <= RP_LOAD;
          st  <= ST_WRP;
        end
        ST_WRP: begin
          if (tmr == '0) st <= ST_REF;
          else           tmr <= tmr - 1'b1;
        end
        ST_REF: begin
          tmr <= RFC_LOAD;
          st  <= ST_RFC;
        end
        ST_RFC: begin
          if (tmr == '0) st <= ST_IDLE;
          else           tmr <= tmr - 1'b1;
        end
        ST_SR: begin
          if (sr_exit) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 icnt <= '0;
    else if (in_sr || sleep)    icnt <= '0;
    else if (icnt == ICNT_TOP)  icnt <= '0;
    else                        icnt <= icnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       posted <= '0;
    else if (sleep || in_sr)          posted <= '0;
    else if (tick && !dec) begin
      if (posted != POST_CAP)         posted <= posted + 1'b1;
    end else if (dec && !tick)        posted <= posted - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 xcnt <= XSRD_V;
    else if (in_sr && sr_exit)  xcnt <= '0;
    else if (xcnt != XSRD_V)    xcnt <= xcnt + 1'b1;
  end
endmodule

module dram_refresh_sched_chk #(
  parameter int T_RP     = 4,
  parameter int T_RFC    = 19,
  parameter int MAX_POST = 8,
  parameter int PW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          ref_urgent,
  input logic [PW-1:0] posted,
  input logic          cmd_pre_all,
  input logic          cmd_refresh,
  input logic          cke,
  input logic          ok_nonread,
  input logic          ok_read
);
  int pre_dist;
  int rfc_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_dist <= 1000;
      rfc_left <= 0;
    end else begin
      if (cmd_pre_all)          pre_dist <= 0;
      else if (pre_dist < 1000) pre_dist <= pre_dist + 1;
      if (cmd_refresh)          rfc_left <= T_RFC - 1;
      else if (rfc_left > 0)    rfc_left <= rfc_left - 1;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(posted) <= MAX_POST);
  a_r3_urgent_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent && ok_nonread) |-> ref_req);
  a_r4_pre_from_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre_all |-> ($past(ref_gnt) && $past(ref_req)));
  a_r4_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refresh |-> (pre_dist == T_RP - 1));
  a_r4_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pre_all, cmd_refresh}));
  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre_all |-> !ref_req);
  a_r5_single_dec: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refresh |-> (posted == $past(posted) || posted == $past(posted) - PW'(1)));
  a_r6_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (rfc_left > 0) |-> (cke && !ok_nonread && !ok_read && !ref_req));
  a_r7_sr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!ref_req && !ok_nonread && posted == '0 && !cmd_pre_all && !cmd_refresh));
  a_r8_read_implies_other: assert property (@(posedge clk) disable iff (!rst_n)
    ok_read |-> ok_nonread);
  a_r8_exit_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !ok_nonread);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .T_RP(T_RP), .T_RFC(T_RFC), .MAX_POST(MAX_POST), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ref_urgent(ref_urgent), .posted(posted), .cmd_pre_all(cmd_pre_all),
  .cmd_refresh(cmd_refresh), .cke(cke), .ok_nonread(ok_nonread), .ok_read(ok_read)
);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int CLK_PS = 4000;
  localparam int REFI_C = 400_000 / CLK_PS;
  localparam int RP_C   = (15_000 + CLK_PS - 1) / CLK_PS;
  localparam int RFC_C  = (75_000 + CLK_PS - 1) / CLK_PS;
  localparam int XSNR_C = (75_000 + CLK_PS - 1) / CLK_PS;
  localparam int XSRD_C = 200;
  localparam int CAP    = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic ref_gnt = 0, sr_enter = 0, sr_exit = 0;
  logic ref_req, ref_urgent, cmd_pre_all, cmd_refresh, cke, ok_nonread, ok_read;
  logic [3:0] posted;

  always #2ns clk = ~clk;

  dram_refresh_sched #(.CLK_PS(CLK_PS), .REFI_PS(400_000)) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .posted(posted), .cmd_pre_all(cmd_pre_all), .cmd_refresh(cmd_refresh),
    .cke(cke), .ok_nonread(ok_nonread), .ok_read(ok_read));

  int cyc = 0;
  int checks = 0;
  int errs = 0;
  int org = 0;
  bit done = 0;

  typedef struct { bit is_ref; int at; } ev_t;
  ev_t q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (cmd_pre_all || cmd_refresh)) begin
      if (q.size() == 0) begin
        check(0, "R4 unexpected command", cmd_refresh ? 2 : 1, 0);
      end else begin
        ev_t e;
        e = q.pop_front();
        check(e.is_ref == cmd_refresh, "R4 command kind", int'(cmd_refresh), int'(e.is_ref));
        check(e.at == cyc, "R4 command cycle", cyc, e.at);
      end
    end
  end

  function automatic int nt(input int x);
    return (x < org) ? 0 : (x - org) / REFI_C;
  endfunction

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic do_refresh(input bit with_sr);
    int c, p, r, t1, t2, e;
    for (int k = 0; k < 60 && !ref_req; k++) @(negedge clk);
    check(ref_req, "R2 request before grant", int'(ref_req), 1);
    c = cyc;
    p = int'(posted);
    r = c + 1 + RP_C;
    q.push_back('{0, c + 1});
    q.push_back('{1, r});
    ref_gnt = 1;
    sr_enter = with_sr;
    @(negedge clk);
    ref_gnt = 0;
    sr_enter = 0;
    check(!ref_req, "R5 request low during sequence", int'(ref_req), 0);
    if (with_sr) check(cke, "R9 grant wins over sr_enter", int'(cke), 1);
    sr_enter = 1;
    @(negedge clk);
    sr_enter = 0;
    @(negedge clk);
    check(cke, "R7 sr_enter ignored mid-sequence", int'(cke), 1);
    wait_cyc(r);
    t1 = nt(r - 1) - nt(c);
    t2 = nt(r) - nt(r - 1);
    e = ((p + t1 > CAP) ? CAP : p + t1) - 1 + t2;
    check(int'(posted) == e, "R5 credit after refresh", int'(posted), e);
    check(ref_urgent == (e == CAP), "R3 urgent tracks credit", int'(ref_urgent), int'(e == CAP));
    wait_cyc(r + RFC_C - 1);
    check(!ok_nonread && cke, "R6 recovery holds", int'(ok_nonread), 0);
    wait_cyc(r + RFC_C);
    check(ok_nonread, "R6 recovery ends", int'(ok_nonread), 1);
  endtask

  initial begin
    int c0, s, x;
    repeat (5) @(negedge clk);
    rst_n = 1;
    c0 = cyc;
    org = c0;
    check(!ref_req && !ref_urgent && !cmd_pre_all && !cmd_refresh, "R1 quiet outputs", int'(ref_req), 0);
    check(posted == 0, "R1 credit zero", int'(posted), 0);
    check(cke && ok_nonread && ok_read, "R1 ready", int'({cke, ok_nonread, ok_read}), 7);

    wait_cyc(c0 + 5);
    ref_gnt = 1;
    @(negedge clk);
    ref_gnt = 0;
    wait_cyc(c0 + REFI_C - 1);
    check(posted == 0 && !ref_req, "R4 grant without request ignored", int'(posted), 0);
    wait_cyc(c0 + REFI_C);
    check(posted == 1, "R2 first tick", int'(posted), 1);
    check(ref_req, "R2 request raised", int'(ref_req), 1);

    do_refresh(1);

    wait_cyc(c0 + 8 * REFI_C);
    check(posted == 7 && !ref_urgent, "R3 seven owed", int'(posted), 7);
    wait_cyc(c0 + 9 * REFI_C);
    check(posted == CAP && ref_urgent, "R3 urgent at cap", int'(posted), CAP);
    wait_cyc(c0 + 10 * REFI_C);
    check(posted == CAP, "R3 saturates", int'(posted), CAP);

    for (int i = 0; i < 14 && posted != 0; i++) do_refresh(0);
    check(posted == 0, "R5 drained", int'(posted), 0);

    @(negedge clk);
    s = cyc;
    sr_enter = 1;
    @(negedge clk);
    sr_enter = 0;
    check(!cke, "R7 cke low in self refresh", int'(cke), 0);
    check(!ref_req && !ok_nonread && !ok_read, "R7 not ready", int'(ok_nonread), 0);
    wait_cyc(s + 5);
    ref_gnt = 1;
    @(negedge clk);
    ref_gnt = 0;
    wait_cyc(s + 1 + 3 * REFI_C);
    check(posted == 0 && !cke, "R7 no ticks in self refresh", int'(posted), 0);

    x = cyc;
    sr_exit = 1;
    @(negedge clk);
    sr_exit = 0;
    org = x + 1;
    check(cke, "R8 cke high after exit", int'(cke), 1);
    wait_cyc(x + XSNR_C);
    check(!ok_nonread, "R8 non-read hold", int'(ok_nonread), 0);
    wait_cyc(x + 1 + XSNR_C);
    check(ok_nonread && !ok_read, "R8 non-read ready", int'({ok_nonread, ok_read}), 2);
    wait_cyc(x + REFI_C);
    check(posted == 0, "R8 interval restarted", int'(posted), 0);
    wait_cyc(x + 1 + REFI_C);
    check(posted == 1, "R8 first tick after exit", int'(posted), 1);
    wait_cyc(x + XSRD_C);
    check(!ok_read, "R8 read hold", int'(ok_read), 0);
    wait_cyc(x + 1 + XSRD_C);
    check(ok_read, "R8 read ready", int'(ok_read), 1);

    for (int i = 0; i < 6 && posted != 0; i++) do_refresh(0);
    check(posted == 0, "R5 drained after exit", int'(posted), 0);
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R4 all commands seen", q.size(), 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule